// File: doc/BRIEF.md
# Four-Beat Prefetch Data Gearbox

This block joins a 128-bit memory core port to a 32-bit double-data-rate pin interface. The design runs on a single internal clock at the pin beat rate, so one cycle of `clk` stands for one half cycle of the interface clock. A core access is always exactly four pin beats.

On the read side, a 128-bit core word is accepted and sent to the pins as four 32-bit beats, lowest 32 bits first. Every byte lane gets its own read strobe. The strobe flips at each beat boundary, so it is edge-aligned with the data, and it rests low when nothing is being sent. On the write side, each byte lane has its own write strobe. A lane samples its data byte and mask bit on every transition of its strobe, rising or falling. The strobe is driven half a cycle away from the sampling clock edge, which places it at the centre of the beat. Once every lane holds four beats, the lanes are merged into one 128-bit word with a 16-bit byte enable. That word is offered to the core for one cycle. If the write window closes before every lane has four beats, the burst is discarded and an error pulse is raised.

Top module: `prefetch_gearbox`

## Requirements
- R1: After reset: `dq_oe`=0, `rdqs`=0, `core_wr_valid`=0, `wr_err`=0 and `rd_ready`=1.
- R2: A word accepted at a clock edge appears on `dq_out` as four beats in the four following cycles. Beat b carries core bits [32b+31:32b], and `dq_oe` is high during exactly those cycles.
- R3: During a burst, all four `rdqs` bits are high on beat 0 and flip at every beat boundary. They are low whenever `dq_oe` is low. Back-to-back bursts keep the flip pattern unbroken.
- R4: `rd_ready` is high when the read side is idle or on the last beat of a burst. A word is accepted only when `rd_load` and `rd_ready` are both high. A `rd_load` while `rd_ready` is low has no effect on the burst in flight.
- R5: While `wr_en` is high, a lane captures its byte of `dq_in` and its bit of `dm_in` on each transition of its bit of `wdqs`, either direction. Lane k is `dq_in[8k+7:8k]`.
- R6: The byte that lane k captures on beat b goes to `core_wr_data[32b+8k+7:32b+8k]`. `core_wr_valid` pulses for one cycle, in the cycle after the edge that captures the last outstanding beat.
- R7: `core_wr_be` bit 4b+k is the inverse of the mask bit captured by lane k on beat b. A mask bit of 1 means the byte is masked.
- R8: Lanes count their beats independently. A lane whose strobe lags the others still completes the word, and the data lands in the correct positions.
- R9: If `wr_en` is low while at least one beat has been captured and the word is incomplete, `wr_err` pulses for one cycle and no `core_wr_valid` is given. The captured beats are discarded, so the next burst is assembled from its own beats only.
- R10: Strobe transitions while `wr_en` is low are not captured. They produce neither `core_wr_valid` nor `wr_err`, and they do not disturb the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock (one cycle per half interface cycle) |
| rst | input | 1 | Synchronous active-high reset |
| rd_load | input | 1 | Request to accept `rd_word` |
| rd_word | input | 128 | Core read word |
| rd_ready | output | 1 | Read side can take a word at this edge |
| dq_out | output | 32 | Read beat driven to the pins |
| dq_oe | output | 1 | Read beat valid / pin drive enable |
| rdqs | output | 4 | Per-lane read strobes |
| wr_en | input | 1 | Write burst window |
| dq_in | input | 32 | Write beat from the pins |
| dm_in | input | 4 | Per-lane write mask (1 = masked) |
| wdqs | input | 4 | Per-lane write strobes |
| core_wr_valid | output | 1 | Assembled write word valid for one cycle |
| core_wr_data | output | 128 | Assembled write word |
| core_wr_be | output | 16 | Byte enables of the assembled word |
| wr_err | output | 1 | Pulse: partial write burst discarded |

## Verification
The hardest case to reach is a write burst whose lanes do not move together. One lane's strobe lags the others, so lanes finish at different edges, and the word must be released only when the slowest lane completes. The bench has a burst task that takes a per-lane delay. It shifts each lane's strobe toggles and data bytes independently. It runs skewed bursts, then a burst cut off at two beats followed by a clean burst, and then strobe toggles with the window closed. Each step checks for stale beats leaking into later words.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    parameter int unsigned LANES_D = 4;
    parameter int unsigned BYTE_D  = 8;
    parameter int unsigned BEATS_D = 4;

    // bit offset in the core word of the byte carried by a lane on a beat
    function automatic int unsigned slot_lsb(input int unsigned beat,
                                             input int unsigned lane,
                                             input int unsigned lanes,
                                             input int unsigned byte_w);
        return (beat * lanes + lane) * byte_w;
    endfunction

    // read serializer sequencing state
    typedef struct packed {
        logic active;
        logic strobe;
    } rd_flags_t;

endpackage

// File: rtl/pfg_rd_serializer.sv
module pfg_rd_serializer
    import pfg_pkg::*;
#(
    parameter int unsigned LANES  = LANES_D,
    parameter int unsigned BYTE_W = BYTE_D,
    parameter int unsigned BEATS  = BEATS_D,
    localparam int unsigned PIN_W  = LANES * BYTE_W,
    localparam int unsigned CORE_W = PIN_W * BEATS,
    localparam int unsigned BW     = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CORE_W-1:0] word,
    output logic              ready,
    output logic [PIN_W-1:0]  dq,
    output logic              oe,
    output logic [LANES-1:0]  strobe
);

    logic [CORE_W-1:0] word_q;
    logic [BW-1:0]     beat_q;
    rd_flags_t         fl_q;
    logic              last;

    assign last  = fl_q.active && (beat_q == BW'(BEATS - 1));
    assign ready = !fl_q.active || last;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            beat_q <= '0;
            fl_q   <= '0;
        end else if (load && ready) begin
            word_q    <= word;
            beat_q    <= '0;
            fl_q.active <= 1'b1;
            fl_q.strobe <= ~fl_q.strobe;
        end else if (fl_q.active) begin
            if (last) begin
                fl_q.active <= 1'b0;
                fl_q.strobe <= 1'b0;
            end else begin
                beat_q      <= beat_q + 1'b1;
                fl_q.strobe <= ~fl_q.strobe;
            end
        end
    end

    assign dq     = fl_q.active ? word_q[beat_q * PIN_W +: PIN_W] : '0;
    assign oe     = fl_q.active;
    assign strobe = {LANES{fl_q.strobe & fl_q.active}};

    // R3: strobe register rests low outside a burst
    a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
        !fl_q.active |-> !fl_q.strobe);

    // R3: strobe flips on every beat while the burst continues
    a_r3_toggle: assert property (@(posedge clk) disable iff (rst)
        (fl_q.active && $past(fl_q.active)) |-> (fl_q.strobe != $past(fl_q.strobe)));

    // R4: word in flight is not replaced before the last beat
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (fl_q.active && !ready) |=> $stable(word_q));

endmodule

// File: rtl/pfg_wr_lane.sv
module pfg_wr_lane
    import pfg_pkg::*;
#(
    parameter int unsigned BYTE_W = BYTE_D,
    parameter int unsigned BEATS  = BEATS_D,
    localparam int unsigned CW    = $clog2(BEATS + 1),
    localparam int unsigned BW    = $clog2(BEATS),
    localparam int unsigned LW    = BEATS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              clear,
    input  logic [BYTE_W-1:0] d,
    input  logic              m,
    input  logic              s,
    output logic              full_next,
    output logic              busy,
    output logic [LW-1:0]     bytes_next,
    output logic [BEATS-1:0]  mask_next
);

    logic              s_q;
    logic [CW-1:0]     cnt_q;
    logic [LW-1:0]     bytes_q;
    logic [BEATS-1:0]  mask_q;
    logic              cap;
    logic              room;
    logic [BW-1:0]     slot;

    assign cap  = accept && (s != s_q);
    assign room = cnt_q < CW'(BEATS);
    assign slot = cnt_q[BW-1:0];

    always_comb begin
        bytes_next = bytes_q;
        mask_next  = mask_q;
        if (cap && room) begin
            bytes_next[slot * BYTE_W +: BYTE_W] = d;
            mask_next[slot]                     = m;
        end
    end

    assign full_next = (cnt_q == CW'(BEATS)) || (cap && cnt_q == CW'(BEATS - 1));
    assign busy      = cnt_q != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= 1'b0;
            cnt_q   <= '0;
            bytes_q <= '0;
            mask_q  <= '0;
        end else begin
            s_q <= s;
            if (clear) begin
                cnt_q <= '0;
            end else if (cap && room) begin
                cnt_q   <= cnt_q + 1'b1;
                bytes_q <= bytes_next;
                mask_q  <= mask_next;
            end
        end
    end

    // R5: a lane never holds more than one word of beats
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(BEATS));

    // R10: with the window closed the beat count cannot advance
    a_r10_closed_hold: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/prefetch_gearbox.sv
module prefetch_gearbox
    import pfg_pkg::*;
#(
    parameter int unsigned LANES  = LANES_D,
    parameter int unsigned BYTE_W = BYTE_D,
    parameter int unsigned BEATS  = BEATS_D,
    localparam int unsigned PIN_W  = LANES * BYTE_W,
    localparam int unsigned CORE_W = PIN_W * BEATS,
    localparam int unsigned BE_W   = LANES * BEATS,
    localparam int unsigned LW     = BEATS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_load,
    input  logic [CORE_W-1:0] rd_word,
    output logic              rd_ready,
    output logic [PIN_W-1:0]  dq_out,
    output logic              dq_oe,
    output logic [LANES-1:0]  rdqs,
    input  logic              wr_en,
    input  logic [PIN_W-1:0]  dq_in,
    input  logic [LANES-1:0]  dm_in,
    input  logic [LANES-1:0]  wdqs,
    output logic              core_wr_valid,
    output logic [CORE_W-1:0] core_wr_data,
    output logic [BE_W-1:0]   core_wr_be,
    output logic              wr_err
);

    pfg_rd_serializer #(
        .LANES (LANES),
        .BYTE_W(BYTE_W),
        .BEATS (BEATS)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .load  (rd_load),
        .word  (rd_word),
        .ready (rd_ready),
        .dq    (dq_out),
        .oe    (dq_oe),
        .strobe(rdqs)
    );

    logic [LANES-1:0] lane_full;
    logic [LANES-1:0] lane_busy;
    logic [LW-1:0]    lane_bytes [LANES];
    logic [BEATS-1:0] lane_mask  [LANES];
    logic             complete;
    logic             abort;
    logic             clear;

    assign complete = wr_en && (&lane_full);
    assign abort    = !wr_en && (|lane_busy);
    assign clear    = complete || abort;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pfg_wr_lane #(
            .BYTE_W(BYTE_W),
            .BEATS (BEATS)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .accept    (wr_en),
            .clear     (clear),
            .d         (dq_in[k * BYTE_W +: BYTE_W]),
            .m         (dm_in[k]),
            .s         (wdqs[k]),
            .full_next (lane_full[k]),
            .busy      (lane_busy[k]),
            .bytes_next(lane_bytes[k]),
            .mask_next (lane_mask[k])
        );
    end

    logic [CORE_W-1:0] asm_data;
    logic [BE_W-1:0]   asm_mask;

    always_comb begin
        asm_data = '0;
        asm_mask = '0;
        for (int b = 0; b < BEATS; b++) begin
            for (int k = 0; k < LANES; k++) begin
                asm_data[slot_lsb(b, k, LANES, BYTE_W) +: BYTE_W] = lane_bytes[k][b * BYTE_W +: BYTE_W];
                asm_mask[b * LANES + k] = lane_mask[k][b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_wr_valid <= 1'b0;
            wr_err        <= 1'b0;
            core_wr_data  <= '0;
            core_wr_be    <= '0;
        end else begin
            core_wr_valid <= complete;
            wr_err        <= abort;
            if (complete) begin
                core_wr_data <= asm_data;
                core_wr_be   <= ~asm_mask;
            end
        end
    end

    // R9: a word is either delivered or dropped, never both
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(core_wr_valid && wr_err));

    // R9: a dropped burst raises a single-cycle error
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> !wr_err);

    // R6: each assembled word is offered for exactly one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        core_wr_valid |=> !core_wr_valid);

    // R3: read strobes are quiet whenever no beat is driven
    a_r3_pins_quiet: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (rdqs == '0));

endmodule

// File: tb/prefetch_gearbox_test.sv
module prefetch_gearbox_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_load = 1'b0;
    logic [127:0] rd_word = '0;
    logic         rd_ready;
    logic [31:0]  dq_out;
    logic         dq_oe;
    logic [3:0]   rdqs;
    logic         wr_en = 1'b0;
    logic [31:0]  dq_in = '0;
    logic [3:0]   dm_in = '0;
    logic [3:0]   wdqs = '0;
    logic         core_wr_valid;
    logic [127:0] core_wr_data;
    logic [15:0]  core_wr_be;
    logic         wr_err;

    int checks = 0;
    int fails  = 0;

    // results gathered by wr_burst
    int           got_v;
    int           got_e;
    logic [127:0] got_d;
    logic [15:0]  got_be;

    always #4 clk = ~clk;

    prefetch_gearbox uut (
        .clk          (clk),
        .rst          (rst),
        .rd_load      (rd_load),
        .rd_word      (rd_word),
        .rd_ready     (rd_ready),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe),
        .rdqs         (rdqs),
        .wr_en        (wr_en),
        .dq_in        (dq_in),
        .dm_in        (dm_in),
        .wdqs         (wdqs),
        .core_wr_valid(core_wr_valid),
        .core_wr_data (core_wr_data),
        .core_wr_be   (core_wr_be),
        .wr_err       (wr_err)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0, "R1 dq_oe after reset", 128'(dq_oe), 0);
        chk(rdqs == 4'h0, "R1 rdqs after reset", 128'(rdqs), 0);
        chk(core_wr_valid == 1'b0, "R1 valid after reset", 128'(core_wr_valid), 0);
        chk(wr_err == 1'b0, "R1 err after reset", 128'(wr_err), 0);
        chk(rd_ready == 1'b1, "R1 ready after reset", 128'(rd_ready), 1);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_beat(input logic [127:0] w, input int b, input string tag);
        chk(dq_out == w[b*32 +: 32], {tag, " R2 beat data"}, 128'(dq_out), 128'(w[b*32 +: 32]));
        chk(dq_oe == 1'b1, {tag, " R2 oe during beat"}, 128'(dq_oe), 1);
        chk(rdqs == ((b % 2 == 0) ? 4'hF : 4'h0), {tag, " R3 strobe level"}, 128'(rdqs),
            128'((b % 2 == 0) ? 4'hF : 4'h0));
        chk(rd_ready == (b == 3), {tag, " R4 ready"}, 128'(rd_ready), 128'(b == 3));
    endtask

    task automatic t_read_single(input logic [127:0] w);
        rd_load = 1'b1;
        rd_word = w;
        @(negedge clk);
        rd_load = 1'b0;
        rd_word = '0;
        for (int b = 0; b < 4; b++) begin
            check_beat(w, b, "single");
            @(negedge clk);
        end
        chk(dq_oe == 1'b0, "R2 oe after burst", 128'(dq_oe), 0);
        chk(rdqs == 4'h0, "R3 strobe idle low", 128'(rdqs), 0);
    endtask

    task automatic t_read_b2b(input logic [127:0] w1, input logic [127:0] w2);
        rd_load = 1'b1;
        rd_word = w1;
        @(negedge clk);
        rd_load = 1'b0;
        for (int b = 0; b < 4; b++) begin
            check_beat(w1, b, "b2b first");
            if (b == 3) begin
                rd_load = 1'b1;
                rd_word = w2;
            end
            @(negedge clk);
        end
        rd_load = 1'b0;
        for (int b = 0; b < 4; b++) begin
            check_beat(w2, b, "b2b second");
            @(negedge clk);
        end
        chk(dq_oe == 1'b0, "R3 b2b ends idle", 128'(dq_oe), 0);
    endtask

    task automatic t_read_ignore(input logic [127:0] w1, input logic [127:0] w2);
        rd_load = 1'b1;
        rd_word = w1;
        @(negedge clk);
        rd_load = 1'b0;
        for (int b = 0; b < 4; b++) begin
            check_beat(w1, b, "ignored load");
            rd_load = (b == 0 || b == 1);
            rd_word = w2;
            @(negedge clk);
        end
        rd_load = 1'b0;
        chk(dq_oe == 1'b0, "R4 load while busy not taken", 128'(dq_oe), 0);
    endtask

    // drive one write burst; skew[l] delays lane l by one cycle; nb beats per lane
    task automatic wr_burst(input logic [127:0] w, input logic [15:0] m, input logic [3:0] skew, input int nb);
        got_v  = 0;
        got_e  = 0;
        got_d  = '0;
        got_be = '0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (core_wr_valid) begin
                got_v++;
                got_d  = core_wr_data;
                got_be = core_wr_be;
            end
            if (wr_err) got_e++;
            if (c <= 4) begin
                wr_en = 1'b1;
                for (int l = 0; l < 4; l++) begin
                    int b;
                    b = c - int'(skew[l]);
                    if (b >= 0 && b < nb) begin
                        wdqs[l]          = ~wdqs[l];
                        dq_in[l*8 +: 8]  = w[(b*4 + l)*8 +: 8];
                        dm_in[l]         = m[b*4 + l];
                    end
                end
            end else begin
                wr_en = 1'b0;
                dq_in = '0;
                dm_in = '0;
            end
        end
    endtask

    task automatic t_write_full(input logic [127:0] w, input logic [15:0] m, input logic [3:0] skew, input string tag);
        wr_burst(w, m, skew, 4);
        chk(got_v == 1, {tag, " R6 one valid pulse"}, 128'(got_v), 1);
        chk(got_d == w, {tag, " R6 assembled data"}, got_d, w);
        chk(got_be == ~m, {tag, " R7 byte enables"}, 128'(got_be), 128'(~m));
        chk(got_e == 0, {tag, " R9 no error on full burst"}, 128'(got_e), 0);
    endtask

    task automatic t_write_partial(input logic [127:0] w);
        wr_burst(w, 16'h0000, 4'h0, 2);
        chk(got_e == 1, "R9 partial burst error", 128'(got_e), 1);
        chk(got_v == 0, "R9 partial burst no valid", 128'(got_v), 0);
    endtask

    task automatic t_write_closed();
        int v = 0;
        int e = 0;
        wr_en = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (core_wr_valid) v++;
            if (wr_err) e++;
            if (c < 3) begin
                wdqs  = ~wdqs;
                dq_in = 32'hDEAD_BEEF;
            end
        end
        if (wdqs != 4'h0) begin
            @(negedge clk);
            wdqs = 4'h0;
            @(negedge clk);
        end
        chk(v == 0, "R10 no valid with window closed", 128'(v), 0);
        chk(e == 0, "R10 no error with window closed", 128'(e), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_read_single(128'h0F0E0D0C_0B0A0908_07060504_03020100);
        t_read_b2b(128'hAAAA0003_AAAA0002_AAAA0001_AAAA0000,
                   128'h5555FFF3_5555FFF2_5555FFF1_5555FFF0);
        t_read_ignore(128'h11111111_22222222_33333333_44444444,
                      128'h99999999_88888888_77777777_66666666);
        // R5 R6 R7: aligned lanes, no mask then sparse mask
        t_write_full(128'h3F3E3D3C_2F2E2D2C_1F1E1D1C_0F0E0D0C, 16'h0000, 4'h0, "aligned");
        t_write_full(128'hCAFEF00D_12345678_9ABCDEF0_0BADC0DE, 16'hA55A, 4'h0, "masked");
        // R8: lagging lanes
        t_write_full(128'h01234567_89ABCDEF_FEDCBA98_76543210, 16'h0F00, 4'b1000, "R8 lane3 late");
        t_write_full(128'h13579BDF_2468ACE0_F0E1D2C3_B4A59687, 16'h8001, 4'b0101, "R8 lanes0,2 late");
        // R9: partial burst then a clean burst must not see stale beats
        t_write_partial(128'hFFFFFFFF_FFFFFFFF_EEEEEEEE_DDDDDDDD);
        t_write_full(128'h44332211_88776655_CCBBAA99_00FFEEDD, 16'h0000, 4'h0, "R9 after abort");
        // R10: closed-window toggles then a clean burst
        t_write_closed();
        t_write_full(128'h600D600D_BEEFBEEF_12121212_34343434, 16'hFFFF, 4'h0, "R10 after closed");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule